// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a single-cycle processor and decides, once per clock, which address the next instruction is fetched from. Four candidates are formed in parallel every cycle: the sequential address (current PC plus 4), a PC-relative branch target, a pseudo-direct jump target, and a target taken from a register operand. A 2-bit select from the control decoder picks one, and the PC register loads it on the rising clock edge.

The branch target has its own adder, so the main ALU can compare the branch operands in the same cycle. The jump target keeps the top four bits of the current PC and fills the rest from the 26-bit jump field, followed by two zero bits. The incremented PC is also exported, so the datapath can write it as a link address. An active-low asynchronous reset returns the PC to address 0.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0, and it takes that value without waiting for a clock edge.
- R2: With `pc_sel_i` = 0 (sequential), the PC after a rising edge equals the PC before it plus 4.
- R3: With `pc_sel_i` = 1 (branch), the PC after a rising edge equals the old PC plus 4 plus `imm_i` shifted left by 2.
- R4: The branch offset treats `imm_i` as two's complement. Bit 15 is the sign, so 0x8000 moves the PC back by 131072 bytes from PC+4, and 0x7FFF moves it forward by 131068.
- R5: With `pc_sel_i` = 2 (jump), the new PC is bits 31:28 of the current PC, then `jump_idx_i[25:0]`, then two zero bits.
- R6: With `pc_sel_i` = 3 (register), the new PC is the full 32-bit `rs_val_i`, with no bits cleared, including the two lowest.
- R7: `pc_plus4_o` always equals `pc_o` + 4 modulo 2^32, in the same cycle.
- R8: Address arithmetic wraps modulo 2^32: a sequential step from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; PC loads on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, PC to 0 |
| pc_sel_i | input | 2 | Next-PC select: 0 seq, 1 branch, 2 jump, 3 register |
| jump_idx_i | input | 26 | Jump field of the instruction |
| imm_i | input | 16 | Branch immediate, two's complement word offset |
| rs_val_i | input | 32 | Register operand used as jump target |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current PC plus 4 |

## Verification
Runs of sequential steps check the incrementer on its own. Branches with a small positive offset, a negative offset and both extreme immediates (0x7FFF, 0x8000) separate correct sign extension from zero extension and from a missing shift. The jump is taken from a PC with a nonzero top nibble and an all-ones jump field, which shows whether the upper bits come from the current PC. A register target with odd low bits, followed by a wrap from 0xFFFFFFFC, exposes any masking or width loss, and a reset applied mid-cycle checks that reset acts without a clock edge.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2,
    NPC_REG    = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pc_next_o
);
  assign pc_next_o = pc_i + ADDR_W'(STEP);
endmodule

// File: rtl/npc_branch_add.sv
module npc_branch_add #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] offset;
  // sign-extend, then scale words to bytes
  assign offset   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign target_o = base_i + offset;
endmodule

// File: rtl/npc_jump_cat.sv
module npc_jump_cat #(
  parameter int ADDR_W = 32,
  parameter int JUMP_W = 26
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [JUMP_W-1:0] jump_idx_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int UP_W = ADDR_W - JUMP_W - 2;

  assign target_o = {pc_i[ADDR_W-1 -: UP_W], jump_idx_i, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              JUMP_W   = 26,
  parameter int              IMM_W    = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pc_sel_i,
  input  logic [JUMP_W-1:0] jump_idx_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] pc_plus4_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_pc;
  logic [ADDR_W-1:0] jmp_pc;
  npc_sel_e          sel;

  npc_incr #(.ADDR_W(ADDR_W), .STEP(4)) u_incr (
    .pc_i      (pc_q),
    .pc_next_o (seq_pc)
  );

  // dedicated adder: ALU is busy with the branch compare
  npc_branch_add #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_br (
    .base_i   (seq_pc),
    .imm_i    (imm_i),
    .target_o (br_pc)
  );

  npc_jump_cat #(.ADDR_W(ADDR_W), .JUMP_W(JUMP_W)) u_jmp (
    .pc_i       (pc_q),
    .jump_idx_i (jump_idx_i),
    .target_o   (jmp_pc)
  );

  assign sel = npc_sel_e'(pc_sel_i);

  always_comb begin
    unique case (sel)
      NPC_BRANCH: pc_d = br_pc;
      NPC_JUMP:   pc_d = jmp_pc;
      NPC_REG:    pc_d = rs_val_i;
      default:    pc_d = seq_pc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RST_ADDR;
    else         pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign pc_plus4_o = seq_pc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int JUMP_W = 26,
  parameter int IMM_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        pc_sel_i,
  input logic [JUMP_W-1:0] jump_idx_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [ADDR_W-1:0] rs_val_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] pc_plus4_o
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;
  localparam int UP_W  = ADDR_W - JUMP_W - 2;

  always @(negedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (pc_o == '0); // R1
    AST_PLUS4_TRACKS: assert (pc_plus4_o == pc_o + ADDR_W'(4)); // R7
  end

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_sel_i == 2'd0 |=> pc_o == $past(pc_o) + ADDR_W'(4)); // R2

  AST_BRANCH_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_sel_i == 2'd1 |=> pc_o == $past(pc_o) + ADDR_W'(4)
      + {{EXT_W{$past(imm_i[IMM_W-1])}}, $past(imm_i), 2'b00}); // R3

  AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_sel_i == 2'd2 |=> pc_o == {$past(pc_o[ADDR_W-1 -: UP_W]), $past(jump_idx_i), 2'b00}); // R5

  AST_REG_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_sel_i == 2'd3 |=> pc_o == $past(rs_val_i)); // R6
endmodule

bind npc_unit npc_unit_chk #(
  .ADDR_W(ADDR_W), .JUMP_W(JUMP_W), .IMM_W(IMM_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_sel_i   (pc_sel_i),
  .jump_idx_i (jump_idx_i),
  .imm_i      (imm_i),
  .rs_val_i   (rs_val_i),
  .pc_o       (pc_o),
  .pc_plus4_o (pc_plus4_o)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  pc_sel_i = 2'd0;
  logic [25:0] jump_idx_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] pc_o;
  logic [31:0] pc_plus4_o;

  int checks = 0;
  int errors = 0;
  longint unsigned model_pc = 0;

  always #5 clk_i = ~clk_i;

  npc_unit u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_sel_i   (pc_sel_i),
    .jump_idx_i (jump_idx_i),
    .imm_i      (imm_i),
    .rs_val_i   (rs_val_i),
    .pc_o       (pc_o),
    .pc_plus4_o (pc_plus4_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural next-PC model, compared after every edge
  task automatic step(string req, logic [1:0] sel, logic [25:0] j, logic [15:0] im, logic [31:0] rs);
    longint signed off;
    pc_sel_i = sel; jump_idx_i = j; imm_i = im; rs_val_i = rs;
    off = longint'(signed'(im)) * 4;
    case (sel)
      2'd0: model_pc = (model_pc + 4) % 64'h1_0000_0000;
      2'd1: model_pc = longint'(unsigned'(64'(model_pc) + 64'd4 + 64'(off))) & 64'hFFFF_FFFF;
      2'd2: model_pc = (model_pc & 64'hF000_0000) | (longint'(j) * 4);
      default: model_pc = rs;
    endcase
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, pc_o, model_pc[31:0]);
    check("R7", pc_plus4_o, 32'((model_pc + 4) % 64'h1_0000_0000));
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1", pc_o, 32'h0);
    check("R7", pc_plus4_o, 32'h4);
    rst_ni = 1'b1;
    model_pc = 0;
    step("R2", 2'd0, '0, '0, '0);
    step("R2", 2'd0, '0, '0, '0);
    step("R2", 2'd0, '0, 16'h1234, 32'hDEAD_BEEF);
    step("R3", 2'd1, '0, 16'h0010, '0);
    step("R4", 2'd1, '0, 16'hFFFD, '0);
    step("R6", 2'd3, '0, '0, 32'h0040_0000);
    step("R4", 2'd1, '0, 16'h7FFF, '0);
    step("R4", 2'd1, '0, 16'h8000, '0);
    step("R6", 2'd3, '0, '0, 32'hA000_0013);
    step("R5", 2'd2, 26'h3FF_FFFF, '0, '0);
    step("R5", 2'd2, 26'h000_0001, '0, 32'hFFFF_FFFF);
    step("R6", 2'd3, '0, '0, 32'hFFFF_FFFC);
    step("R8", 2'd0, '0, '0, '0);
    step("R2", 2'd0, '0, '0, '0);
    step("R6", 2'd3, '0, '0, 32'h1234_5678);
    // reset mid-cycle must act at once
    #2 rst_ni = 1'b0;
    #1 check("R1", pc_o, 32'h0);
    @(negedge clk_i);
    check("R1", pc_o, 32'h0);
    rst_ni = 1'b1;
    model_pc = 0;
    step("R2", 2'd0, '0, '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule